// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block produces the refresh workload for an asynchronous DRAM array. A free-running interval timer marks one refresh as owed every `TICK_CYCLES` clocks. The default of 3900 clocks at 4 ns is 15.6 µs. That is a little faster than the average spacing needed to fit 1024 refreshes into each 16.4 ms period. A small ledger counts the refreshes that are owed but not yet performed, so a grant that comes late costs no refresh. The ledger saturates at `OWED_MAX`. A tick that arrives while the ledger is full sets a sticky overflow flag.

While any refresh is owed, the block raises `ref_req` toward the access sequencer that owns the DRAM control pins, and waits for `ref_gnt`. Once granted, it takes the pins and runs one CAS-before-RAS cycle. No row address is needed, because the DRAM keeps its own refresh row counter. The cycle runs in four steps:

- CAS goes low first, with write-enable high.
- RAS then goes low for its active time, with CAS held low.
- Both strobes rise, and the block keeps driving them high for the precharge time.
- The block releases the pins and pulses `ref_done` for one cycle.

The controller has six states: `ST_IDLE`, `ST_WAIT_GNT`, `ST_CAS_LEAD`, `ST_RAS_ACT`, `ST_PRECHARGE` and `ST_DONE`. Its transitions are:

- `ST_IDLE` → `ST_WAIT_GNT` when a refresh is owed.
- `ST_WAIT_GNT` → `ST_CAS_LEAD` when a grant is seen.
- `ST_CAS_LEAD` → `ST_RAS_ACT` after `CSR_CYCLES`.
- `ST_RAS_ACT` → `ST_PRECHARGE` after `RAS_CYCLES`.
- `ST_PRECHARGE` → `ST_DONE` after `PRE_CYCLES`.
- `ST_DONE` → `ST_IDLE` always.

Top module: `cbr_refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `pin_drive`, `ref_done` and `owed_ovf` are low, and `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high.
- R2: One refresh becomes owed every `TICK_CYCLES` clocks from reset. `ref_req` stays low until the first refresh is owed, and goes high once one is owed.
- R3: While no grant has been seen, `pin_drive` stays low and all three strobes stay high (1 = inactive), however long the grant is withheld.
- R4: After a grant, `dram_cas_n` goes low with `dram_ras_n` high for exactly `CSR_CYCLES` cycles before `dram_ras_n` falls. There is never a driven cycle with RAS low and CAS high.
- R5: `dram_ras_n` stays low for exactly `RAS_CYCLES` cycles, and `dram_cas_n` stays low throughout.
- R6: `dram_we_n` is high in every cycle in which the pins are driven.
- R7: After RAS rises, both strobes are driven high for exactly `PRE_CYCLES` cycles before `pin_drive` drops.
- R8: `ref_done` is a one-cycle pulse in the cycle where `pin_drive` has just dropped, and `ref_req` is low in that cycle.
- R9: Owed refreshes accumulate up to `OWED_MAX`. With the grant then held, exactly that many refreshes run back to back, after which `ref_req` drops.
- R10: `owed_ovf` is set when a tick arrives while `OWED_MAX` refreshes are already owed. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Grant of the DRAM control pins from the access sequencer |
| ref_req | output | 1 | Request for the DRAM control pins |
| pin_drive | output | 1 | High while this block owns the DRAM control pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low; kept high |
| ref_done | output | 1 | One-cycle pulse when a refresh cycle completes |
| owed_ovf | output | 1 | Sticky flag: a refresh was lost to ledger saturation |

## Verification
A ledger that has lost count shows up at the ports in two ways. In the saturation scenario the wrong number of back-to-back `ref_done` pulses appears. Alternatively, `ref_req` stays high or drops too early within about one refresh time (31 clocks) of the backlog draining. A phase counter that reloads wrongly shows up in the first granted cycle, as a CAS lead, RAS width or precharge count that differs from its parameter. A state machine that takes the pins early shows up as `pin_drive` rising during the grant-withholding windows of several lengths.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_CAS_LEAD,
        ST_RAS_ACT,
        ST_PRECHARGE,
        ST_DONE
    } cbr_state_e;
endpackage

// File: rtl/cbr_tick_gen.sv
module cbr_tick_gen #(
    parameter int unsigned PERIOD = 3900
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (PERIOD > 1) begin : g_spacing
            // R2: ticks are spaced, never back to back
            assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cbr_owed_ledger.sv
module cbr_owed_ledger #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic consume,
    output logic pending,
    output logic overflow
);
    localparam int unsigned OW = $clog2(LIMIT + 1);
    localparam logic [OW-1:0] TOP = OW'(LIMIT);

    logic [OW-1:0] owed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed     <= '0;
            overflow <= 1'b0;
        end else begin
            unique case ({tick, consume})
                2'b10: begin
                    if (owed == TOP) overflow <= 1'b1;
                    else             owed     <= owed + 1'b1;
                end
                2'b01: begin
                    if (owed != '0) owed <= owed - 1'b1;
                end
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);

    assert_owed_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= TOP);
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(owed) == TOP && $past(tick)));
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
    import cbr_pkg::*;
#(
    parameter int unsigned CSR_CYCLES = 3,
    parameter int unsigned RAS_CYCLES = 15,
    parameter int unsigned PRE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic gnt,
    output logic req,
    output logic drive,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic done
);
    localparam int unsigned M1 = (CSR_CYCLES > RAS_CYCLES) ? CSR_CYCLES : RAS_CYCLES;
    localparam int unsigned MX = (M1 > PRE_CYCLES) ? M1 : PRE_CYCLES;
    localparam int unsigned CW = $clog2(MX + 1);

    cbr_state_e    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = (cnt == '0) ? '0 : cnt - 1'b1;
        unique case (state)
            ST_IDLE: begin
                if (pending) state_nxt = ST_WAIT_GNT;
            end
            ST_WAIT_GNT: begin
                if (gnt) begin
                    state_nxt = ST_CAS_LEAD;
                    cnt_nxt   = CW'(CSR_CYCLES - 1);
                end
            end
            ST_CAS_LEAD: begin
                if (cnt == '0) begin
                    state_nxt = ST_RAS_ACT;
                    cnt_nxt   = CW'(RAS_CYCLES - 1);
                end
            end
            ST_RAS_ACT: begin
                if (cnt == '0) begin
                    state_nxt = ST_PRECHARGE;
                    cnt_nxt   = CW'(PRE_CYCLES - 1);
                end
            end
            ST_PRECHARGE: begin
                if (cnt == '0) state_nxt = ST_DONE;
            end
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        req   = 1'b0;
        drive = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        done  = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_WAIT_GNT:  req = 1'b1;
            ST_CAS_LEAD:  begin req = 1'b1; drive = 1'b1; cas_n = 1'b0; end
            ST_RAS_ACT:   begin req = 1'b1; drive = 1'b1; cas_n = 1'b0; ras_n = 1'b0; end
            ST_PRECHARGE: begin req = 1'b1; drive = 1'b1; end
            ST_DONE:      done = 1'b1;
            default:      ;
        endcase
    end

    // R4: RAS falls only while CAS was already low
    assert_cas_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !$past(cas_n));
    // R5: CAS held low for the whole RAS-low window
    assert_cas_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);
    // R3: pins taken only after a grant was seen
    assert_grant_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(gnt));
    // R8: completion is a single-cycle pulse following release
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive) |-> done);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
    parameter int unsigned TICK_CYCLES = 3900,
    parameter int unsigned OWED_MAX    = 8,
    parameter int unsigned CSR_CYCLES  = 3,
    parameter int unsigned RAS_CYCLES  = 15,
    parameter int unsigned PRE_CYCLES  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic pin_drive,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n,
    output logic ref_done,
    output logic owed_ovf
);
    logic tick;
    logic pending;

    cbr_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cbr_owed_ledger #(.LIMIT(OWED_MAX)) u_ledger (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .consume  (ref_done),
        .pending  (pending),
        .overflow (owed_ovf)
    );

    cbr_seq #(
        .CSR_CYCLES (CSR_CYCLES),
        .RAS_CYCLES (RAS_CYCLES),
        .PRE_CYCLES (PRE_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .gnt     (ref_gnt),
        .req     (ref_req),
        .drive   (pin_drive),
        .ras_n   (dram_ras_n),
        .cas_n   (dram_cas_n),
        .we_n    (dram_we_n),
        .done    (ref_done)
    );

    // R6: write enable stays inactive whenever the pins are driven
    assert_we_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive |-> dram_we_n);
    // R3: strobes idle whenever the pins are not owned
    assert_idle_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_drive |-> (dram_ras_n && dram_cas_n));
endmodule

// File: tb/cbr_refresh_sched_bench.sv
`timescale 1ns/1ps
module cbr_refresh_sched_bench;
    localparam int TICK = 200;
    localparam int OMAX = 4;
    localparam int CSR  = 3;
    localparam int RAS  = 15;
    localparam int PRE  = 10;
    localparam int NVEC = 6;
    // columns: grant delay, expected CAS lead, expected RAS width, expected precharge
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{0,  CSR, RAS, PRE},
        '{1,  CSR, RAS, PRE},
        '{3,  CSR, RAS, PRE},
        '{7,  CSR, RAS, PRE},
        '{12, CSR, RAS, PRE},
        '{20, CSR, RAS, PRE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, pin_drive, dram_ras_n, dram_cas_n, dram_we_n, ref_done, owed_ovf;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cbr_refresh_sched #(
        .TICK_CYCLES (TICK),
        .OWED_MAX    (OMAX),
        .CSR_CYCLES  (CSR),
        .RAS_CYCLES  (RAS),
        .PRE_CYCLES  (PRE)
    ) u_cbr_refresh_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .pin_drive  (pin_drive),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .ref_done   (ref_done),
        .owed_ovf   (owed_ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        ref_gnt = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input int dly, input int ecsr, input int eras, input int epre);
        int n = 0;
        int hold_bad = 0;
        int cs = 0, rs = 0, ps = 0;
        int order_bad = 0, we_bad = 0, phase = 0;
        bit seen_done = 1'b0;
        while (!ref_req && n < 400) begin
            @(negedge clk);
            if (pin_drive || !dram_ras_n || !dram_cas_n) hold_bad++;
            n++;
        end
        chk(ref_req, "R2 req raised when owed", int'(ref_req), 1);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (pin_drive || !dram_ras_n || !dram_cas_n || !dram_we_n || !ref_req) hold_bad++;
        end
        chk(hold_bad == 0, "R3 pins idle before grant", hold_bad, 0);
        ref_gnt = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (ref_done) begin seen_done = 1'b1; break; end
            if (pin_drive) begin
                if (!dram_we_n) we_bad++;
                if (dram_ras_n && !dram_cas_n) begin cs++; if (phase > 1) order_bad++; phase = 1; end
                else if (!dram_ras_n && !dram_cas_n) begin rs++; if (phase > 2 || phase < 1) order_bad++; phase = 2; end
                else if (dram_ras_n && dram_cas_n) begin ps++; if (phase < 2) order_bad++; phase = 3; end
                else order_bad++;
            end
        end
        chk(cs == ecsr, "R4 CAS lead cycles", cs, ecsr);
        chk(order_bad == 0, "R4 strobe order", order_bad, 0);
        chk(rs == eras, "R5 RAS low cycles", rs, eras);
        chk(we_bad == 0, "R6 write enable high", we_bad, 0);
        chk(ps == epre, "R7 precharge cycles", ps, epre);
        chk(seen_done && !pin_drive && !ref_req, "R8 done at release",
            int'(seen_done && !pin_drive && !ref_req), 1);
        ref_gnt = 1'b0;
        @(negedge clk);
        chk(!ref_done, "R8 done single cycle", int'(ref_done), 0);
    endtask

    initial begin
        int dones;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(!ref_req && !pin_drive && !ref_done && !owed_ovf, "R1 reset outputs low",
            int'({ref_req, pin_drive, ref_done, owed_ovf}), 0);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 reset strobes high",
            int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);

        // R2: nothing owed before the first interval, owed after it
        repeat (149) @(negedge clk);
        chk(!ref_req, "R2 no request before first tick", int'(ref_req), 0);
        repeat (80) @(negedge clk);
        chk(ref_req && !pin_drive, "R2/R3 request pending, pins idle",
            int'({ref_req, pin_drive}), 2);

        // R9/R10: withhold grant until the ledger saturates and overflows
        repeat (670) @(negedge clk);
        chk(!owed_ovf && !pin_drive, "R10 no overflow at limit", int'(owed_ovf), 0);
        repeat (110) @(negedge clk);
        chk(owed_ovf, "R10 overflow after extra tick", int'(owed_ovf), 1);
        ref_gnt = 1'b1;
        dones = 0;
        for (int i = 0; i < 170; i++) begin
            @(negedge clk);
            if (ref_done) dones++;
        end
        chk(dones == OMAX, "R9 back-to-back refreshes equal limit", dones, OMAX);
        chk(!ref_req && !pin_drive, "R9 request drops after backlog", int'(ref_req), 0);
        chk(owed_ovf, "R10 overflow sticky", int'(owed_ovf), 1);
        ref_gnt = 1'b0;

        // table of grant latencies
        do_reset();
        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

        // R1: reset clears the sticky flag
        do_reset();
        @(negedge clk);
        chk(!owed_ovf && !ref_req, "R1 reset clears flag and request",
            int'({owed_ovf, ref_req}), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule